// File: doc/BRIEF.md
# Flash Embedded-Operation Status Encoder

This block forms the byte a host reads back from a NOR flash device while an internal program or erase algorithm is running, or while an erase is suspended. It captures one value on each rising edge of the read strobe. Depending on the operating mode, that value is either the stored array data or a status pattern. The status pattern has three live bits: bit 7 is a polling bit that reports the complement of the bit being written, bit 6 is a toggle bit, and bit 2 is a sector toggle bit.

The two toggle bits are independent. Bit 6 flips on every read during any active algorithm, at any address. Bit 2 flips only on reads that land in a sector marked for erase, whether that sector is erasing now or suspended. A host can therefore tell which sector is suspended by watching bit 2 change across reads, even while it programs or reads other locations.

The read strobe, mode and address flags are plain control inputs with no handshake. The value is captured at the rising edge of the strobe and stays on `rd_data` until the next rising edge. Back-pressure does not arise: each strobe rise produces exactly one capture, and no other condition changes the output.

Top module: `flash_status_encoder`

## Requirements
- R1: After reset, `rd_data` is 0 and both toggle bits start from 0.
- R2: The value for a read is taken on the first clock edge that sees `rd_strobe` high after it was low. It appears on `rd_data` after that edge and is held until the next such rise. With `op_mode` = 0 (read mode; codes 5 to 7 behave the same), `rd_data` equals `array_data`.
- R3: With `op_mode` = 1 (program), a read returns bit 7 = NOT `wr_bit7`, bit 6 = the toggle bit, and bit 2 = 1.
- R4: With `op_mode` = 2 (erase), a read returns bit 7 = 0 and bit 6 = the toggle bit. Bit 2 shows the sector toggle bit, which advances only on reads with `in_erase_sector` = 1.
- R5: With `op_mode` = 3 (suspend read), a read with `in_erase_sector` = 1 returns bit 7 = 1, bit 6 = 1, and bit 2 = the sector toggle bit, which then advances.
- R6: With `op_mode` = 3, a read with `in_erase_sector` = 0 returns `array_data` and leaves both toggle bits unchanged.
- R7: With `op_mode` = 4 (suspend program), a read returns bit 7 = NOT `wr_bit7` and bit 6 = the toggle bit, which advances.
- R8: With `op_mode` = 4, a read with `at_prog_addr` = 1 returns bit 2 = 1 and does not advance the sector toggle bit. Otherwise bit 2 shows the sector toggle bit, which advances when `in_erase_sector` = 1.
- R9: A toggle bit inverts at most once per strobe rise, and reports its value from before that inversion. The first status read after a clear returns 0 and the next returns 1. Holding the strobe high does not advance it again.
- R10: Any cycle in read mode clears both toggle bits to 0.
- R11: In a status read, bits 5, 4, 3, 1 and 0, and all bits above 7, are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_mode | input | 3 | 0 read, 1 program, 2 erase, 3 suspend read, 4 suspend program |
| rd_strobe | input | 1 | Read strobe; a rise captures one value |
| in_erase_sector | input | 1 | Read address lies in a sector marked for erase |
| at_prog_addr | input | 1 | Read address equals the address being programmed |
| wr_bit7 | input | 1 | True bit 7 of the data being programmed |
| array_data | input | DATA_W | Stored array contents at the read address |
| rd_data | output | DATA_W | Captured read value |

## Verification
On every cycle, the assertions check the following:
- the program-mode polling and bit 2 value;
- the erase-mode bit 7;
- the fixed 1s of a suspended-sector read;
- the zero padding;
- that `rd_data` holds between strobe rises;
- that read mode clears the toggles;
- that bit 6 flips once per status read.

Only the bench's scenarios can show the longer behaviours:
- the alternating sequence of toggle values across many reads;
- that bit 2 stays frozen across reads outside the erase sector or at the program address;
- that a toggle state survives the switch from erase into a suspend mode;
- that the first read after a return to read mode restarts at 0.

// File: rtl/fses_pkg.sv
package fses_pkg;
  typedef enum logic [2:0] {
    MODE_READ    = 3'd0,
    MODE_PROG    = 3'd1,
    MODE_ERASE   = 3'd2,
    MODE_SUSP_RD = 3'd3,
    MODE_SUSP_PG = 3'd4
  } op_mode_e;

  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;
  localparam int unsigned SECT_BIT = 2;
  localparam int unsigned NUM_TOG  = 2;
  localparam int unsigned IDX_T6   = 0;
  localparam int unsigned IDX_T2   = 1;
endpackage

// File: rtl/fses_strobe_edge.sv
module fses_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strobe;
  end

  assign rise = strobe & ~prev_q;
endmodule

// File: rtl/fses_toggle_bank.sv
module fses_toggle_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [N-1:0] advance,
  output logic [N-1:0] tog_q
);
  for (genvar i = 0; i < N; i++) begin : g_tog
    always_ff @(posedge clk) begin
      if (!rst_n || clear) tog_q[i] <= 1'b0;
      else if (advance[i]) tog_q[i] <= ~tog_q[i];
    end
  end
endmodule

// File: rtl/fses_status_mux.sv
module fses_status_mux
  import fses_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [2:0]        op_mode,
  input  logic              tog6,
  input  logic              tog2,
  input  logic              in_erase_sector,
  input  logic              at_prog_addr,
  input  logic              wr_bit7,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] next_data,
  output logic              want6,
  output logic              want2,
  output logic              clear
);
  logic [DATA_W-1:0] status;
  logic              use_status;

  always_comb begin
    status     = '0;
    use_status = 1'b0;
    want6      = 1'b0;
    want2      = 1'b0;
    clear      = 1'b0;
    case (op_mode)
      MODE_PROG: begin
        use_status       = 1'b1;
        status[POLL_BIT] = ~wr_bit7;
        status[TOG_BIT]  = tog6;
        status[SECT_BIT] = 1'b1;
        want6            = 1'b1;
      end
      MODE_ERASE: begin
        use_status       = 1'b1;
        status[TOG_BIT]  = tog6;
        status[SECT_BIT] = tog2;
        want6            = 1'b1;
        want2            = in_erase_sector;
      end
      MODE_SUSP_RD: begin
        if (in_erase_sector) begin
          use_status       = 1'b1;
          status[POLL_BIT] = 1'b1;
          status[TOG_BIT]  = 1'b1;
          status[SECT_BIT] = tog2;
          want2            = 1'b1;
        end
      end
      MODE_SUSP_PG: begin
        use_status       = 1'b1;
        status[POLL_BIT] = ~wr_bit7;
        status[TOG_BIT]  = tog6;
        status[SECT_BIT] = at_prog_addr ? 1'b1 : tog2;
        want6            = 1'b1;
        want2            = in_erase_sector & ~at_prog_addr;
      end
      default: clear = 1'b1;
    endcase
    next_data = use_status ? status : array_data;
  end
endmodule

// File: rtl/flash_status_encoder.sv
module flash_status_encoder
  import fses_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_mode,
  input  logic              rd_strobe,
  input  logic              in_erase_sector,
  input  logic              at_prog_addr,
  input  logic              wr_bit7,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);
  logic               rise;
  logic [NUM_TOG-1:0] tog_q;
  logic [NUM_TOG-1:0] advance;
  logic               tog6_q, tog2_q;
  logic               want6, want2, clear;
  logic [DATA_W-1:0]  next_data;

  fses_strobe_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (rd_strobe),
    .rise   (rise)
  );

  fses_status_mux #(.DATA_W(DATA_W)) u_mux (
    .op_mode         (op_mode),
    .tog6            (tog6_q),
    .tog2            (tog2_q),
    .in_erase_sector (in_erase_sector),
    .at_prog_addr    (at_prog_addr),
    .wr_bit7         (wr_bit7),
    .array_data      (array_data),
    .next_data       (next_data),
    .want6           (want6),
    .want2           (want2),
    .clear           (clear)
  );

  assign advance[IDX_T6] = rise & want6;
  assign advance[IDX_T2] = rise & want2;

  fses_toggle_bank #(.N(NUM_TOG)) u_tog (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .advance (advance),
    .tog_q   (tog_q)
  );

  assign tog6_q = tog_q[IDX_T6];
  assign tog2_q = tog_q[IDX_T2];

  always_ff @(posedge clk) begin
    if (!rst_n)    rd_data <= '0;
    else if (rise) rd_data <= next_data;
  end
endmodule

// File: rtl/flash_status_encoder_chk.sv
module flash_status_encoder_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_mode,
  input logic              rd_strobe,
  input logic              in_erase_sector,
  input logic              wr_bit7,
  input logic [DATA_W-1:0] rd_data,
  input logic              tog6_q,
  input logic              tog2_q
);
  logic ck_prev;
  logic ck_rise;
  logic ck_stat;
  logic ck_tmode;

  always_ff @(posedge clk) begin
    if (!rst_n) ck_prev <= 1'b0;
    else        ck_prev <= rd_strobe;
  end

  assign ck_rise  = rd_strobe & ~ck_prev;
  assign ck_tmode = (op_mode == 3'd1) || (op_mode == 3'd2) || (op_mode == 3'd4);
  assign ck_stat  = ck_tmode || ((op_mode == 3'd3) && in_erase_sector);

  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_rise && op_mode == 3'd1) |=> (rd_data[7] == ~$past(wr_bit7) && rd_data[2])); // R3

  AST_ERASE_POLL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_rise && op_mode == 3'd2) |=> (rd_data[7] == 1'b0)); // R4

  AST_SUSP_SECTOR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_rise && op_mode == 3'd3 && in_erase_sector) |=> (rd_data[7:6] == 2'b11)); // R5

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_rise && ck_stat) |=> ((rd_data[5:3] == 3'b000) && (rd_data[1:0] == 2'b00) && ((rd_data >> 8) == '0))); // R11

  AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ck_rise) |=> $stable(rd_data)); // R9

  AST_TOG6_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_rise && ck_tmode) |=> (tog6_q != $past(tog6_q))); // R9

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 3'd0) |=> (!tog6_q && !tog2_q)); // R10
endmodule

bind flash_status_encoder flash_status_encoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .op_mode         (op_mode),
  .rd_strobe       (rd_strobe),
  .in_erase_sector (in_erase_sector),
  .wr_bit7         (wr_bit7),
  .rd_data         (rd_data),
  .tog6_q          (tog6_q),
  .tog2_q          (tog2_q)
);

// File: tb/tb_flash_status_encoder.sv
`timescale 1ns/1ps
module tb_flash_status_encoder;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   op_mode = 3'd0;
  logic         rd_strobe = 1'b0;
  logic         in_erase_sector = 1'b0;
  logic         at_prog_addr = 1'b0;
  logic         wr_bit7 = 1'b0;
  logic [W-1:0] array_data = '0;
  logic [W-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit m6 = 1'b0, m2 = 1'b0;

  always #2 clk = ~clk;

  flash_status_encoder #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .rd_strobe(rd_strobe),
    .in_erase_sector(in_erase_sector), .at_prog_addr(at_prog_addr),
    .wr_bit7(wr_bit7), .array_data(array_data), .rd_data(rd_data)
  );

  function automatic logic [7:0] expect_val(input logic [2:0] m, input bit s, input bit p,
                                            input bit w7, input logic [7:0] a, input bit t6, input bit t2);
    logic [7:0] v;
    v = 8'h00;
    case (m)
      3'd1: begin v[7] = ~w7; v[6] = t6; v[2] = 1'b1; end
      3'd2: begin v[6] = t6; v[2] = t2; end
      3'd3: if (s) begin v[7] = 1'b1; v[6] = 1'b1; v[2] = t2; end else v = a;
      3'd4: begin v[7] = ~w7; v[6] = t6; v[2] = p ? 1'b1 : t2; end
      default: v = a;
    endcase
    return v;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input string req, input logic [2:0] m, input bit s, input bit p,
                         input bit w7, input logic [7:0] a, input int hold);
    logic [7:0] e;
    @(negedge clk);
    op_mode = m; in_erase_sector = s; at_prog_addr = p; wr_bit7 = w7; array_data = a;
    rd_strobe = 1'b1;
    if (m == 3'd0 || m > 3'd4) begin m6 = 1'b0; m2 = 1'b0; end
    e = expect_val(m, s, p, w7, a, m6, m2);
    if (m == 3'd1 || m == 3'd2 || m == 3'd4) m6 = ~m6;
    if ((m == 3'd2 && s) || (m == 3'd3 && s) || (m == 3'd4 && s && !p)) m2 = ~m2;
    @(negedge clk);
    check(req, rd_data, e);
    for (int i = 0; i < hold; i++) @(negedge clk);
    if (hold > 0) check({req, " held"}, rd_data, e);
    rd_strobe = 1'b0;
    @(negedge clk);
    check({req, " stable"}, rd_data, e);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_F1A5));
    repeat (3) @(negedge clk);
    check("R1 reset", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", rd_data, 8'h00);

    do_read("R2 read mode", 3'd0, 1'b0, 1'b0, 1'b0, 8'hA5, 0);
    do_read("R2 read mode code 6", 3'd6, 1'b1, 1'b0, 1'b1, 8'h3C, 0);
    do_read("R3 program first", 3'd1, 1'b0, 1'b0, 1'b1, 8'hFF, 0);
    do_read("R3 program second", 3'd1, 1'b1, 1'b0, 1'b0, 8'hFF, 0);
    do_read("R9 program held strobe", 3'd1, 1'b0, 1'b0, 1'b0, 8'h00, 3);
    do_read("R9 program after hold", 3'd1, 1'b0, 1'b0, 1'b0, 8'h00, 0);
    do_read("R10 back to read", 3'd0, 1'b0, 1'b0, 1'b0, 8'h11, 0);
    do_read("R10 first status after clear", 3'd1, 1'b0, 1'b0, 1'b1, 8'h00, 0);
    do_read("R10 clear again", 3'd0, 1'b0, 1'b0, 1'b0, 8'h22, 0);
    do_read("R4 erase in sector", 3'd2, 1'b1, 1'b0, 1'b0, 8'hFF, 0);
    do_read("R4 erase outside sector", 3'd2, 1'b0, 1'b0, 1'b0, 8'hFF, 0);
    do_read("R4 erase outside again", 3'd2, 1'b0, 1'b0, 1'b0, 8'hFF, 0);
    do_read("R4 erase in sector again", 3'd2, 1'b1, 1'b0, 1'b1, 8'hFF, 0);
    do_read("R5 suspend read in sector", 3'd3, 1'b1, 1'b0, 1'b0, 8'h5A, 0);
    do_read("R6 suspend read outside", 3'd3, 1'b0, 1'b0, 1'b0, 8'h5A, 0);
    do_read("R6 toggles untouched", 3'd3, 1'b1, 1'b0, 1'b0, 8'h5A, 0);
    do_read("R7 suspend program", 3'd4, 1'b0, 1'b0, 1'b1, 8'hEE, 0);
    do_read("R8 program address", 3'd4, 1'b1, 1'b1, 1'b0, 8'hEE, 0);
    do_read("R8 program address again", 3'd4, 1'b1, 1'b1, 1'b0, 8'hEE, 0);
    do_read("R8 suspended sector", 3'd4, 1'b1, 1'b0, 1'b0, 8'hEE, 0);
    do_read("R8 suspended sector again", 3'd4, 1'b1, 1'b0, 1'b1, 8'hEE, 0);
    do_read("R11 padding erase", 3'd2, 1'b1, 1'b0, 1'b1, 8'hFF, 0);

    for (int n = 0; n < 300; n++) begin
      logic [2:0] rm;
      rm = 3'($urandom_range(0, 5));
      do_read("R2-R11 random (R9 model)", rm, 1'($urandom), 1'($urandom),
              1'($urandom), 8'($urandom), int'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule